// File: doc/BRIEF.md
# Configurable Serial CRC Engine

This block computes a cyclic redundancy check one bit per clock. Software sets it up through a small register-write port. It chooses a generator polynomial of degree 1 to 16, a data word length of 1 to 16 bits and the order in which bits enter. It also chooses whether the engine appends zero bits on its own after each word. Software seeds the accumulator and then supplies data words. Each word enters through a two-step write: first the upper byte, then the lower byte, and the lower-byte write launches the word.

While a word is being shifted, a busy output is high. When busy drops, a sticky event flag is raised. An interrupt output follows that flag when the interrupt enable is set. A data write that arrives while busy is dropped and is recorded in a sticky overrun bit. Any final inversion or XOR of the result is left to software.

The register port is a plain write strobe with an address and does not apply back-pressure. Software is expected to wait for busy to fall before it launches the next word. A launch made too early is discarded and reported through the overrun bit, never queued.

Register map (3-bit address, 16-bit write data):
- 0 mode: [3:0] word length minus one, [4] LSB-first order, [5] auto zero append, [6] interrupt enable
- 1 polynomial taps: the coefficients below the top term
- 2 degree: [3:0] polynomial degree minus one
- 3 accumulator seed
- 4 upper data byte in [7:0]
- 5 lower data byte in [7:0], which launches the word
- 6 clear: bit 0 clears the event flag, bit 1 clears overrun

Top module: `crc_serial_engine`

## Requirements
- R1: After reset the accumulator reads 0, and busy, the event flag, overrun and the interrupt are all low.
- R2: A write to address 3 while idle loads the accumulator with the full 16-bit value on the next clock. A seed write while busy is ignored. While idle and not seeded, the accumulator holds its value.
- R3: A write to address 5 while idle latches the word {upper byte, lower byte} and raises busy on the next clock. Busy then stays high for exactly L clocks, or L+N clocks with auto zero append, where L is the word length and N is the polynomial degree.
- R4: With bit 4 of the mode register clear, bit L−1 of the word enters first and bit 0 enters last. Word bits at positions L and above have no effect.
- R5: With bit 4 of the mode register set, bit 0 enters first and bit L−1 enters last. Word bits at positions L and above have no effect.
- R6: With auto zero append set, N zero bits follow the data, and the accumulator then holds the check value. This equals feeding the same word without append and then an N-bit zero word.
- R7: With auto zero append clear, shifting stops after the L data bits. Feeding the check value afterwards as an N-bit word, MSB first, leaves the accumulator at 0. For x^16+x^15+x^2+1 (taps 0x8005) with seed 0, the bytes "123456789" followed by a zero word give 0xFEE8.
- R8: Each shifted bit b does the following. It takes f = acc[N−1], shifts acc left by one with b entering at bit 0, and clears bits N and above. If f is 1 it then XORs in the taps from address 1, masked to N bits.
- R9: The event flag is set on every clock where busy falls, whatever the enable. It stays set until a clear write with bit 0 set.
- R10: The interrupt output is high exactly when the event flag and the interrupt enable are both set.
- R11: A write to address 5 while busy is ignored: the word in flight and its result are unchanged. It sets overrun, which stays set until a clear write with bit 1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| crc_acc | output | 16 | Accumulator value |
| busy | output | 1 | Word shift in progress |
| irq_flag | output | 1 | Sticky end-of-word event flag |
| irq | output | 1 | Flag gated by the interrupt enable |
| overrun | output | 1 | Sticky dropped-launch indicator |

## Verification
A seed write shows on the accumulator one clock after the write edge. Busy rises one clock after a launch and falls after exactly L or L+N further clocks. The accumulator's final value and the event flag land on the same edge that clears busy, and overrun is set one clock after a rejected launch. The bench drives writes and samples all outputs on falling clock edges. It counts the falling edges with busy high to measure the span. It reads the result only at the first falling edge where busy is low, and sets each expected value from a bitwise reference built from R8.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
  localparam int unsigned ACC_W  = 16;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LEN_W  = $clog2(DATA_W);
  localparam int unsigned PLEN_W = $clog2(ACC_W);
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    RA_MODE   = 3'd0,
    RA_TAPS   = 3'd1,
    RA_DEGREE = 3'd2,
    RA_SEED   = 3'd3,
    RA_DHI    = 3'd4,
    RA_DLO    = 3'd5,
    RA_CLEAR  = 3'd6,
    RA_SPARE  = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic             irq_en;
    logic             zero_append;
    logic             lsb_first;
    logic [LEN_W-1:0] len_m1;
  } mode_t;
endpackage

// File: rtl/crc_cfg_regs.sv
module crc_cfg_regs
  import crc_eng_pkg::*;
#(
  parameter int unsigned REG_W = ACC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              busy,
  output mode_t             mode,
  output logic [ACC_W-1:0]  taps,
  output logic [PLEN_W-1:0] degree_m1,
  output logic [DATA_W-1:0] data_word,
  output logic              launch,
  output logic              launch_drop,
  output logic              seed_we,
  output logic              clr_flag,
  output logic              clr_ovr
);
  localparam int unsigned HI_W   = DATA_W - BYTE_W;
  localparam int unsigned MODE_W = $bits(mode_t);

  reg_addr_e        sel;
  logic [HI_W-1:0]  data_hi;

  assign sel = reg_addr_e'(addr);

  always_comb begin
    launch      = 1'b0;
    launch_drop = 1'b0;
    seed_we     = 1'b0;
    clr_flag    = 1'b0;
    clr_ovr     = 1'b0;
    if (we) begin
      unique case (sel)
        RA_DLO: begin
          launch      = !busy;
          launch_drop = busy;
        end
        RA_SEED:  seed_we = !busy;
        RA_CLEAR: begin
          clr_flag = wdata[0];
          clr_ovr  = wdata[1];
        end
        default: ;
      endcase
    end
  end

  assign data_word = {data_hi, wdata[BYTE_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= '{irq_en: 1'b0, zero_append: 1'b0, lsb_first: 1'b0, len_m1: '1};
      taps      <= '0;
      degree_m1 <= '1;
      data_hi   <= '0;
    end else if (we) begin
      unique case (sel)
        RA_MODE:   mode      <= mode_t'(wdata[MODE_W-1:0]);
        RA_TAPS:   taps      <= wdata[ACC_W-1:0];
        RA_DEGREE: degree_m1 <= wdata[PLEN_W-1:0];
        RA_DHI:    data_hi   <= wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/crc_bit_sequencer.sv
module crc_bit_sequencer
  import crc_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [DATA_W-1:0] word,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              lsb_first,
  input  logic              zero_append,
  input  logic [PLEN_W-1:0] degree_m1,
  output logic              busy,
  output logic              bit_out,
  output logic              done
);
  localparam int unsigned CNT_W = $clog2(DATA_W + ACC_W + 1);

  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] len_mask;
  logic [DATA_W-1:0] load_val;
  logic [CNT_W-1:0]  remain;
  logic [CNT_W-1:0]  total;
  logic              lsb_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_lmask
    assign len_mask[i] = (LEN_W'(i) <= len_m1);
  end

  always_comb begin
    total = CNT_W'(len_m1) + CNT_W'(1);
    if (zero_append) total = total + CNT_W'(degree_m1) + CNT_W'(1);
  end

  always_comb begin
    if (lsb_first) load_val = word & len_mask;
    else           load_val = word << (LEN_W'(DATA_W - 1) - len_m1);
  end

  assign bit_out = lsb_q ? shreg[0] : shreg[DATA_W-1];
  assign done    = busy && (remain == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      remain <= '0;
      busy   <= 1'b0;
      lsb_q  <= 1'b0;
    end else if (launch) begin
      shreg  <= load_val;
      remain <= total;
      busy   <= 1'b1;
      lsb_q  <= lsb_first;
    end else if (busy) begin
      shreg  <= lsb_q ? (shreg >> 1) : (shreg << 1);
      remain <= remain - CNT_W'(1);
      if (remain == CNT_W'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/crc_lfsr_acc.sv
module crc_lfsr_acc
  import crc_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_we,
  input  logic [ACC_W-1:0]  seed_val,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic [ACC_W-1:0]  taps,
  input  logic [PLEN_W-1:0] degree_m1,
  output logic [ACC_W-1:0]  acc
);
  logic [ACC_W-1:0] shifted;
  logic [ACC_W-1:0] keep;
  logic [ACC_W-1:0] nxt;
  logic             fb;

  assign fb = acc[degree_m1];

  for (genvar i = 0; i < ACC_W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign shifted[i] = bit_in;
    end else begin : g_up
      assign shifted[i] = acc[i-1];
    end
    assign keep[i] = (PLEN_W'(i) <= degree_m1);
    assign nxt[i]  = keep[i] & (shifted[i] ^ (fb & taps[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc <= '0;
    else if (seed_we)  acc <= seed_val;
    else if (shift_en) acc <= nxt;
  end
endmodule

// File: rtl/crc_irq_ctrl.sv
module crc_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic launch_drop,
  input  logic clr_flag,
  input  logic clr_ovr,
  input  logic irq_en,
  output logic irq_flag,
  output logic overrun,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (done)          irq_flag <= 1'b1;
      else if (clr_flag) irq_flag <= 1'b0;
      if (launch_drop)   overrun  <= 1'b1;
      else if (clr_ovr)  overrun  <= 1'b0;
    end
  end

  assign irq = irq_flag & irq_en;
endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
  import crc_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [ACC_W-1:0]  reg_wdata,
  output logic [ACC_W-1:0]  crc_acc,
  output logic              busy,
  output logic              irq_flag,
  output logic              irq,
  output logic              overrun
);
  mode_t             mode;
  logic [ACC_W-1:0]  taps;
  logic [PLEN_W-1:0] degree_m1;
  logic [DATA_W-1:0] data_word;
  logic              launch;
  logic              launch_drop;
  logic              seed_we;
  logic              clr_flag;
  logic              clr_ovr;
  logic              ser_bit;
  logic              done;

  crc_cfg_regs #(.REG_W(ACC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .mode(mode), .taps(taps), .degree_m1(degree_m1),
    .data_word(data_word), .launch(launch), .launch_drop(launch_drop),
    .seed_we(seed_we), .clr_flag(clr_flag), .clr_ovr(clr_ovr)
  );

  crc_bit_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .word(data_word),
    .len_m1(mode.len_m1), .lsb_first(mode.lsb_first),
    .zero_append(mode.zero_append), .degree_m1(degree_m1),
    .busy(busy), .bit_out(ser_bit), .done(done)
  );

  crc_lfsr_acc u_acc (
    .clk(clk), .rst_n(rst_n), .seed_we(seed_we), .seed_val(reg_wdata),
    .shift_en(busy), .bit_in(ser_bit), .taps(taps), .degree_m1(degree_m1),
    .acc(crc_acc)
  );

  crc_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .done(done), .launch_drop(launch_drop),
    .clr_flag(clr_flag), .clr_ovr(clr_ovr), .irq_en(mode.irq_en),
    .irq_flag(irq_flag), .overrun(overrun), .irq(irq)
  );
endmodule

// File: rtl/crc_serial_engine_checker.sv
module crc_serial_engine_checker
  import crc_eng_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              irq_flag,
  input logic              overrun,
  input logic [ACC_W-1:0]  crc_acc,
  input logic              launch,
  input logic              launch_drop,
  input logic              seed_we,
  input logic [ACC_W-1:0]  seed_val,
  input logic              clr_flag,
  input logic [LEN_W-1:0]  len_m1,
  input logic              zero_append,
  input logic [PLEN_W-1:0] degree_m1
);
  localparam int unsigned CW = $clog2(DATA_W + ACC_W + 1) + 1;

  logic [CW-1:0] run_cnt;
  logic [CW-1:0] exp_span;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      exp_span <= '0;
    end else if (launch) begin
      run_cnt  <= '0;
      exp_span <= CW'(len_m1) + CW'(1) + (zero_append ? CW'(degree_m1) + CW'(1) : CW'(0));
    end else if (busy) begin
      run_cnt  <= run_cnt + CW'(1);
    end
  end

  assert_busy_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == exp_span));

  assert_launch_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  assert_seed_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seed_we |=> (crc_acc == $past(seed_val)));

  assert_acc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !seed_we) |=> $stable(crc_acc));

  assert_flag_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq_flag);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !clr_flag) |=> irq_flag);

  assert_overrun_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    launch_drop |=> overrun);
endmodule

bind crc_serial_engine crc_serial_engine_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq_flag(irq_flag), .overrun(overrun),
  .crc_acc(crc_acc), .launch(launch), .launch_drop(launch_drop),
  .seed_we(seed_we), .seed_val(reg_wdata), .clr_flag(clr_flag),
  .len_m1(mode.len_m1), .zero_append(mode.zero_append), .degree_m1(degree_m1)
);

// File: tb/crc_serial_engine_test.sv
module crc_serial_engine_test;
  localparam logic [2:0] A_MODE = 3'd0, A_TAPS = 3'd1, A_DEG = 3'd2, A_SEED = 3'd3,
                         A_DHI = 3'd4, A_DLO = 3'd5, A_CLR = 3'd6;

  typedef struct packed {
    logic [6:0]  mode;
    logic [15:0] taps;
    logic [3:0]  deg_m1;
    logic [15:0] seed;
    logic [15:0] data;
  } vec_t;

  // mode: [6] irq enable, [5] zero append, [4] LSB first, [3:0] length-1
  localparam vec_t VECS [8] = '{
    '{7'h2F, 16'h8005, 4'd15, 16'h0000, 16'h3132},
    '{7'h27, 16'h8005, 4'd15, 16'hFFFF, 16'hAB5A},
    '{7'h3B, 16'h8005, 4'd15, 16'h1234, 16'hFABC},
    '{7'h1F, 16'h8005, 4'd15, 16'h0000, 16'hC3A5},
    '{7'h20, 16'h0003, 4'd2,  16'h0000, 16'h0001},
    '{7'h04, 16'h0007, 4'd7,  16'h005A, 16'hFF1F},
    '{7'h2F, 16'h1021, 4'd15, 16'hFFFF, 16'h0000},
    '{7'h36, 16'h0003, 4'd3,  16'h0000, 16'h807F}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] crc_acc;
  logic        busy, irq_flag, irq, overrun;
  int          checks = 0;
  int          failures = 0;

  always #5 clk = ~clk;

  crc_serial_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .crc_acc(crc_acc), .busy(busy),
    .irq_flag(irq_flag), .irq(irq), .overrun(overrun)
  );

  function automatic logic [15:0] ref_crc(input logic [15:0] seed, input logic [15:0] taps,
      input int n, input logic [15:0] data, input int len, input bit lsb, input bit app);
    logic [15:0] a = seed;
    logic [15:0] m = (n == 16) ? 16'hFFFF : ((16'h1 << n) - 16'h1);
    int total = len + (app ? n : 0);
    for (int i = 0; i < total; i++) begin
      logic b = (i < len) ? (lsb ? data[i] : data[len-1-i]) : 1'b0;
      logic f = a[n-1];
      a = ((a << 1) | {15'h0, b}) & m;
      if (f) a = a ^ (taps & m);
    end
    return a;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle(output int span);
    span = 0;
    while (busy === 1'b1 && span < 200) begin
      span++;
      @(negedge clk);
    end
  endtask

  task automatic send_word(input logic [15:0] d, output int span);
    wr(A_DHI, {8'h00, d[15:8]});
    wr(A_DLO, {8'h00, d[7:0]});
    wait_idle(span);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int span;
    logic [15:0] expv;
    logic [15:0] chkval;
    string tag;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 acc", crc_acc, 16'h0000);
    chk("R1 flags", {12'h0, busy, irq_flag, irq, overrun}, 16'h0000);

    // Table walk: R2 seed, R3 span, R4/R5 order, R8 step, R9 flag
    foreach (VECS[k]) begin
      vec_t v = VECS[k];
      int n = int'(v.deg_m1) + 1;
      int len = int'(v.mode[3:0]) + 1;
      wr(A_MODE, {9'h0, v.mode});
      wr(A_TAPS, v.taps);
      wr(A_DEG, {12'h0, v.deg_m1});
      wr(A_SEED, v.seed);
      chk("R2 seed", crc_acc, v.seed);
      wr(A_CLR, 16'h0003);
      send_word(v.data, span);
      chk("R3 span", 16'(span), 16'(len + (v.mode[5] ? n : 0)));
      expv = ref_crc(v.seed, v.taps, n, v.data, len, v.mode[4], v.mode[5]);
      tag = v.mode[4] ? "R5 R8 acc" : "R4 R8 acc";
      chk(tag, crc_acc, expv);
      chk("R9 flag", {15'h0, irq_flag}, 16'h0001);
    end

    // R4 upper bits ignored: same low byte, different upper byte, length 8
    wr(A_MODE, 16'h0027); wr(A_TAPS, 16'h8005); wr(A_DEG, 16'h000F);
    wr(A_SEED, 16'h0000); send_word(16'hFF5A, span);
    chk("R4 upper ignored", crc_acc, ref_crc(16'h0, 16'h8005, 16, 16'h005A, 8, 1'b0, 1'b1));
    // R5 upper bits ignored in LSB-first order, length 8 with append
    wr(A_MODE, 16'h0037); wr(A_SEED, 16'h0000); send_word(16'hC35A, span);
    chk("R5 upper ignored", crc_acc, ref_crc(16'h0, 16'h8005, 16, 16'h005A, 8, 1'b1, 1'b1));

    // R6: appended result equals no-append plus an N-bit zero word
    wr(A_MODE, 16'h002F); wr(A_SEED, 16'h0000); send_word(16'h3132, span);
    chkval = crc_acc;
    wr(A_MODE, 16'h000F); wr(A_SEED, 16'h0000); send_word(16'h3132, span);
    send_word(16'h0000, span);
    chk("R6 append equals zero word", crc_acc, chkval);

    // R7 known answer: bytes "123456789", no append, then zero word
    wr(A_MODE, 16'h0007); wr(A_SEED, 16'h0000);
    for (int i = 0; i < 9; i++) send_word(16'(8'h31 + i), span);
    chk("R7 stop after data", 16'(span), 16'd8);
    wr(A_MODE, 16'h000F); send_word(16'h0000, span);
    chk("R7 known answer", crc_acc, 16'hFEE8);
    // R7: feeding the check value leaves zero
    wr(A_MODE, 16'h0007); wr(A_SEED, 16'h0000);
    for (int i = 0; i < 9; i++) send_word(16'(8'h31 + i), span);
    wr(A_MODE, 16'h000F); send_word(16'hFEE8, span);
    chk("R7 residue zero", crc_acc, 16'h0000);

    // R11 and R2: launch and seed while busy are ignored
    wr(A_MODE, 16'h002F); wr(A_SEED, 16'h0000); wr(A_CLR, 16'h0003);
    wr(A_DHI, 16'h0012); wr(A_DLO, 16'h0034);
    wr(A_SEED, 16'hBEEF);
    wr(A_DLO, 16'h0099);
    chk("R11 overrun set", {15'h0, overrun}, 16'h0001);
    wait_idle(span);
    chk("R11 word unchanged", crc_acc, ref_crc(16'h0, 16'h8005, 16, 16'h1234, 16, 1'b0, 1'b1));
    repeat (4) @(negedge clk);
    chk("R2 idle hold", crc_acc, ref_crc(16'h0, 16'h8005, 16, 16'h1234, 16, 1'b0, 1'b1));
    chk("R11 overrun sticky", {15'h0, overrun}, 16'h0001);
    wr(A_CLR, 16'h0002);
    chk("R11 overrun cleared", {15'h0, overrun}, 16'h0000);

    // R9 and R10: flag with enable clear, then enable, then clear
    chk("R9 flag sticky", {15'h0, irq_flag}, 16'h0001);
    chk("R10 irq masked", {15'h0, irq}, 16'h0000);
    wr(A_MODE, 16'h006F);
    chk("R10 irq enabled", {15'h0, irq}, 16'h0001);
    wr(A_CLR, 16'h0001);
    chk("R9 flag cleared", {15'h0, irq_flag}, 16'h0000);
    chk("R10 irq follows flag", {15'h0, irq}, 16'h0000);

    finish_run();
  end
endmodule